// File: doc/BRIEF.md
# Serial-Selected Debug Probe Multiplexer

This block puts one of several internal 16-bit signal groups onto a 16-pin debug header, where an external logic analyzer can watch it. The group shown on the header is chosen while the chip runs, with no rebuild of the design. An operator types one ASCII digit into a serial terminal, and a small receiver on the block's own clock decodes the character. From that point the header carries the matching group.

The receive line passes through a two-flop synchronizer. The receiver then samples it at 16 times the bit rate, taking each bit at its midpoint. The block trusts only a well-formed 8N1 frame: a start bit that has gone high again by its midpoint is treated as a glitch, and a frame whose stop bit is low is dropped. Any character that does not name a group leaves the selection alone. The header output is registered, so the pins change only on a clock edge. The current selection is shown on a small status output.

Top module: `dbg_probe_router`

## Requirements
- R1: Receiving ASCII '1' to '8' (0x31 to 0x38) selects group 0 to 7. Group k is bits [16k+15:16k] of `probe_bus_i`.
- R2: A correctly framed character outside 0x31 to 0x38 leaves `sel_o` and the routed group unchanged.
- R3: While reset is asserted, `sel_o` is 0 and `probe_o` is 0. After reset the selection is group 0.
- R4: On every cycle after reset, `probe_o` equals the group that `sel_o` named one cycle earlier, taken from the value `probe_bus_i` had one cycle earlier.
- R5: A frame is made of a low start bit, 8 data bits sent LSB first, and a high stop bit. Each bit lasts 16*`OS_DIV` clock cycles.
- R6: A frame whose stop bit is sampled low is discarded. The receiver then waits for the line to return high before it looks for a new start bit.
- R7: A low pulse that has ended before the midpoint of a start bit (8*`OS_DIV` cycles) starts no frame and changes nothing.
- R8: `sel_o` stays unchanged while a frame's data bits arrive. It takes the new value before the stop bit ends, once the stop bit has been sampled at its midpoint.
- R9: The selection can change any number of times during operation. It changes only as the result of a valid, in-range frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the receiver's sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| probe_bus_i | input | 128 | Eight 16-bit probe groups, group k in bits [16k+15:16k] |
| probe_o | output | 16 | Registered debug header output |
| sel_o | output | 3 | Index of the group currently routed |

## Verification
Two things can land on the same clock edge: the receiver accepting a selection, and the probe register capturing new group data. The bench changes `probe_bus_i` to a fresh random value on every cycle while frames arrive. This means the edge that updates the selection also captures new data. On each cycle the header is compared with the group that `sel_o` named one cycle before, using the bus value from that same earlier cycle. A switch that leaks early or late by one cycle, or that mixes old and new groups, shows up as a mismatch on exactly that edge.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int          OS_RATE    = 16;
  localparam int          OS_MID     = OS_RATE / 2 - 1;
  localparam logic [7:0]  CHAR_FIRST = 8'h31;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAITHI
  } rx_state_e;
endpackage

// File: rtl/dpr_sync2.sv
module dpr_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/dpr_uart_rx.sv
module dpr_uart_rx
  import dpr_pkg::*;
#(
  parameter int OS_DIV = 14,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o
);
  localparam int DIV_W = (OS_DIV > 1) ? $clog2(OS_DIV) : 1;
  localparam int IDX_W = (DW > 1) ? $clog2(DW) : 1;

  rx_state_e        state_q, state_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [3:0]       os_q, os_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [DW-1:0]    shf_q, shf_d;
  logic [DW-1:0]    data_q, data_d;
  logic             valid_q, valid_d;
  logic             tick;
  logic             busy;

  assign tick = (div_q == DIV_W'(OS_DIV - 1));
  assign busy = (state_q == RX_START) || (state_q == RX_DATA) || (state_q == RX_STOP);

  always_comb begin
    state_d = state_q;
    div_d   = div_q;
    os_d    = os_q;
    idx_d   = idx_q;
    shf_d   = shf_q;
    data_d  = data_q;
    valid_d = 1'b0;
    if (busy) begin
      div_d = tick ? '0 : div_q + 1'b1;
      if (tick) os_d = os_q + 4'd1;
    end
    case (state_q)
      RX_IDLE: begin
        if (!rx_i) begin
          state_d = RX_START;
          div_d   = '0;
          os_d    = '0;
        end
      end
      RX_START: begin
        if (tick && os_q == 4'(OS_MID)) begin
          if (rx_i) begin
            state_d = RX_IDLE;
          end else begin
            state_d = RX_DATA;
            os_d    = '0;
            idx_d   = '0;
          end
        end
      end
      RX_DATA: begin
        if (tick && os_q == 4'(OS_RATE - 1)) begin
          shf_d = {rx_i, shf_q[DW-1:1]};
          if (idx_q == IDX_W'(DW - 1)) state_d = RX_STOP;
          else                         idx_d   = idx_q + 1'b1;
        end
      end
      RX_STOP: begin
        if (tick && os_q == 4'(OS_RATE - 1)) begin
          if (rx_i) begin
            valid_d = 1'b1;
            data_d  = shf_q;
            state_d = RX_IDLE;
          end else begin
            state_d = RX_WAITHI;
          end
        end
      end
      RX_WAITHI: begin
        if (rx_i) state_d = RX_IDLE;
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      div_q   <= '0;
      os_q    <= '0;
      idx_q   <= '0;
      shf_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      div_q   <= div_d;
      os_q    <= os_d;
      idx_q   <= idx_d;
      shf_q   <= shf_d;
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  // R5: an accepted character is reported for a single cycle
  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R6: a character is only delivered when the line was high at the stop sample
  a_r6_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(rx_i));

  // R6: after a low stop bit nothing is delivered on the next cycle
  a_r6_no_deliver_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_WAITHI) |=> !valid_q);
endmodule

// File: rtl/dpr_sel_decode.sv
module dpr_sel_decode
  import dpr_pkg::*;
#(
  parameter int NGRP  = 8,
  parameter int SEL_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [7:0]       char_i,
  output logic [SEL_W-1:0] sel_o
);
  localparam logic [8:0] CHAR_END = {1'b0, CHAR_FIRST} + 9'(NGRP);

  logic [SEL_W-1:0] sel_q, sel_d;
  logic             in_range;
  logic [7:0]       offset;

  assign in_range = ({1'b0, char_i} >= {1'b0, CHAR_FIRST}) && ({1'b0, char_i} < CHAR_END);
  assign offset   = char_i - CHAR_FIRST;

  always_comb begin
    sel_d = sel_q;
    if (valid_i && in_range) sel_d = offset[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign sel_o = sel_q;

  // R9: the selection moves only on a delivered character
  a_r9_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(valid_i) |-> $stable(sel_q));

  // R2: a delivered character outside the digit range is ignored
  a_r2_ignore_char: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_i && (char_i < CHAR_FIRST || {1'b0, char_i} >= CHAR_END)) |-> $stable(sel_q));
endmodule

// File: rtl/dpr_probe_mux.sv
module dpr_probe_mux #(
  parameter int NGRP  = 8,
  parameter int PW    = 16,
  parameter int SEL_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NGRP*PW-1:0] bus_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [PW-1:0]      probe_o
);
  logic [PW-1:0] grp [NGRP];
  logic [PW-1:0] probe_q, probe_d;

  for (genvar g = 0; g < NGRP; g++) begin : g_slice
    assign grp[g] = bus_i[g*PW +: PW];
  end

  always_comb begin
    probe_d = '0;
    for (int k = 0; k < NGRP; k++) begin
      if (sel_i == SEL_W'(k)) probe_d = grp[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) probe_q <= '0;
    else        probe_q <= probe_d;
  end

  assign probe_o = probe_q;
endmodule

// File: rtl/dbg_probe_router.sv
module dbg_probe_router #(
  parameter int NGRP   = 8,
  parameter int PW     = 16,
  parameter int OS_DIV = 14
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     rx_i,
  input  logic [NGRP*PW-1:0]                       probe_bus_i,
  output logic [PW-1:0]                            probe_o,
  output logic [((NGRP > 1) ? $clog2(NGRP) : 1)-1:0] sel_o
);
  localparam int SEL_W = (NGRP > 1) ? $clog2(NGRP) : 1;

  logic             rst_sync_n;
  logic             rx_sync;
  logic [7:0]       rx_char;
  logic             rx_valid;
  logic [SEL_W-1:0] sel;

  dpr_sync2 #(.RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  dpr_sync2 #(.RST_VAL(1'b1)) u_rx_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (rx_i),
    .q_o   (rx_sync)
  );

  dpr_uart_rx #(.OS_DIV(OS_DIV), .DW(8)) u_rx (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rx_i    (rx_sync),
    .data_o  (rx_char),
    .valid_o (rx_valid)
  );

  dpr_sel_decode #(.NGRP(NGRP), .SEL_W(SEL_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .valid_i (rx_valid),
    .char_i  (rx_char),
    .sel_o   (sel)
  );

  dpr_probe_mux #(.NGRP(NGRP), .PW(PW), .SEL_W(SEL_W)) u_mux (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .bus_i   (probe_bus_i),
    .sel_i   (sel),
    .probe_o (probe_o)
  );

  assign sel_o = sel;

  logic chk_live_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) chk_live_q <= 1'b0;
    else             chk_live_q <= 1'b1;
  end

  // R4: header shows last cycle's group as named by last cycle's selection
  a_r4_probe_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chk_live_q |-> (probe_o == $past(probe_bus_i[sel_o*PW +: PW])));

  // R3: during reset the header and selection are cleared
  a_r3_reset_state: assert property (@(posedge clk)
    !rst_sync_n |-> (probe_o == '0 && sel_o == '0));
endmodule

// File: tb/dbg_probe_router_tb_top.sv
module dbg_probe_router_tb_top;
  localparam int NGRP = 8;
  localparam int PW   = 16;
  localparam int DIV  = 4;
  localparam int BIT  = 16 * DIV;

  logic                 clk;
  logic                 rst_n;
  logic                 rx;
  logic [NGRP*PW-1:0]   bus;
  logic [PW-1:0]        probe_o;
  logic [2:0]           sel_o;

  int checks;
  int fails;
  bit mon_en;
  bit done;
  logic [2:0] exp_sel;
  logic [NGRP*PW-1:0] prev_bus;
  logic [2:0]         prev_sel;

  dbg_probe_router #(.NGRP(NGRP), .PW(PW), .OS_DIV(DIV)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_i        (rx),
    .probe_bus_i (bus),
    .probe_o     (probe_o),
    .sel_o       (sel_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit is_digit(input logic [7:0] c);
    return (c >= 8'h31) && (c <= 8'h38);
  endfunction

  function automatic logic [2:0] digit_sel(input logic [7:0] c);
    logic [7:0] t;
    t = c - 8'h31;
    return t[2:0];
  endfunction

  function automatic logic [PW-1:0] group_of(input logic [NGRP*PW-1:0] b, input logic [2:0] k);
    return b[k*PW +: PW];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic send_frame(input logic [7:0] c, input bit good_stop, input string req);
    logic [2:0] old;
    old = exp_sel;
    rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = c[i];
      repeat (BIT) @(negedge clk);
    end
    // R8: no change before the stop bit is sampled
    check(sel_o == old, "R8", sel_o, old);
    rx = good_stop;
    repeat (BIT) @(negedge clk);
    if (!good_stop) begin
      rx = 1'b1;
      repeat (BIT) @(negedge clk);
    end
    if (good_stop && is_digit(c)) exp_sel = digit_sel(c);
    check(sel_o == exp_sel, req, sel_o, exp_sel);
  endtask

  task automatic glitch(input int len);
    rx = 1'b0;
    repeat (len) @(negedge clk);
    rx = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    check(sel_o == exp_sel, "R7", sel_o, exp_sel);
  endtask

  // bus driver and per-cycle header monitor (R4)
  initial begin
    bus = '0;
    prev_bus = '0;
    prev_sel = '0;
    forever begin
      @(negedge clk);
      if (mon_en) begin
        check(probe_o == group_of(prev_bus, prev_sel), "R4",
              probe_o, group_of(prev_bus, prev_sel));
      end
      for (int k = 0; k < NGRP * PW / 32; k++) bus[k*32 +: 32] = $urandom;
      prev_bus = bus;
      prev_sel = sel_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] c;
    void'($urandom(32'h0005_eed5));
    checks = 0;
    fails = 0;
    done = 1'b0;
    mon_en = 1'b0;
    exp_sel = '0;
    rx = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check(probe_o == '0, "R3", probe_o, 0);
    check(sel_o == '0, "R3", sel_o, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    mon_en = 1'b1;
    check(sel_o == 3'd0, "R3", sel_o, 0);

    // R1: every digit maps to its group
    for (int d = 0; d < 8; d++) send_frame(8'h31 + 8'(d), 1'b1, "R1");
    send_frame("3", 1'b1, "R1");

    // R2: framed characters outside the digit range
    send_frame("0", 1'b1, "R2");
    send_frame("9", 1'b1, "R2");
    send_frame(8'h00, 1'b1, "R2");
    send_frame(8'hFF, 1'b1, "R2");
    send_frame("a", 1'b1, "R2");
    send_frame(8'hB2, 1'b1, "R2");

    // R6: bad stop bit discarded, next good frame still accepted
    send_frame("6", 1'b0, "R6");
    send_frame("5", 1'b1, "R6");

    // R7: short low pulses, including one just under half a bit
    glitch(3 * DIV);
    glitch(7 * DIV);
    send_frame("2", 1'b1, "R7");

    // R5/R9: random characters sent back to back
    for (int n = 0; n < 30; n++) begin
      c = ($urandom_range(0, 1) == 0) ? 8'h31 + 8'($urandom_range(0, 7)) : 8'($urandom);
      send_frame(c, 1'b1, "R9");
    end
    send_frame("8", 1'b1, "R5");
    send_frame("1", 1'b1, "R5");

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule